// File: doc/BRIEF.md
# Dual-Comparator General-Purpose Timer

One 16-bit timer channel driven by software writes. A setup word selects one of two time bases, which arrive as single-cycle enable pulses (a fast one and a slow one). It also sets a power-of-two prescale, an output mode and a run bit. The up-counter advances once per prescaled tick. It wraps back to zero on the step after it has matched the second comparator, so comparator 2 sets the period.

The first comparator has two uses. In event mode it produces a one-cycle pulse on `cmp_out_o` when the counter arrives at its value. In PWM mode it produces a level that stays high while the counter is greater than or equal to it. Two sticky flags record that the counter arrived at comparator 1 or at comparator 2. Software clears them by writing ones. The interrupt output combines each flag with its own enable input.

The configuration part of the setup word can be written only once after reset. The run bit and the flag-clear bits remain writable.

Top module: `gp_timer`

## Requirements
- R1: With prescale field n (setup bits [3:0]), the counter advances once per 2^n pulses of the selected time base. Writing the counter restarts the prescaler, so the first step after a counter write comes exactly 2^n base pulses later.
- R2: Setup bit 4 selects the fast time base when 1 and the slow one when 0. Pulses on the unselected base have no effect.
- R3: On a step where the counter equals comparator 2, the counter becomes 0. With comparator 2 at 0xFFFF the counter runs 0xFFFE, 0xFFFF, 0.
- R4: Setup bit 6 is the run bit. While it is 0 the counter holds its value.
- R5: Flag bit 7 (comparator 1) and flag bit 8 (comparator 2) are set on a step that brings the counter to the matching comparator value. If a set and a clear land on the same clock, the set wins.
- R6: Writing 1 to setup bit 7 or 8 clears that flag. Writing 0 to it leaves the flag as it was.
- R7: Setup bit 9 reads 1 after the first setup write. From then on, writes to bits [5:0] are ignored until reset.
- R8: Setup bit 5 selects PWM mode. In PWM mode `cmp_out_o` is high while counter >= comparator 1. In event mode it is high for exactly one cycle after the step that brings the counter to comparator 1.
- R9: `irq_o` is (flag7 AND `irq_en1_i`) OR (flag8 AND `irq_en2_i`), and it stays high until the flag is cleared.
- R10: Register select 1 writes the counter directly, select 2 writes comparator 1 and select 3 writes comparator 2. Select 0 writes the setup word. After reset the counter is 0, comparator 2 is 0xFFFF and setup reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast_i | input | 1 | Fast time-base enable pulse |
| tick_slow_i | input | 1 | Slow time-base enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 setup, 1 counter, 2 cmp1, 3 cmp2 |
| wr_data_i | input | 16 | Write data |
| irq_en1_i | input | 1 | Interrupt enable for comparator 1 flag |
| irq_en2_i | input | 1 | Interrupt enable for comparator 2 flag |
| setup_o | output | 16 | Setup readback |
| count_o | output | 16 | Counter value |
| cmp_out_o | output | 1 | Event pulse or PWM level |
| irq_o | output | 1 | Combined interrupt level |

## Verification
Two things can land on the same clock edge: a software write-1-to-clear of the comparator 1 flag, and the counter step that sets that flag. The bench arranges this by timing the setup write to arrive on exactly the edge where the counter reaches comparator 1. It then checks that the flag and the interrupt are still high. A second collision also gets a check: a counter write that coincides with a prescaled step must restart the count instead of advancing it.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
  typedef enum logic [1:0] {
    SEL_SETUP = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CMP1  = 2'd2,
    SEL_CMP2  = 2'd3
  } reg_sel_e;

  localparam int PS_W     = 4;
  localparam int CFG_W    = 6;
  localparam int BIT_RUN  = 6;
  localparam int BIT_F1   = 7;
  localparam int BIT_F2   = 8;
  localparam int BIT_INIT = 9;

  typedef struct packed {
    logic            pwm;
    logic            csel;
    logic [PS_W-1:0] ps;
  } cfg_t;
endpackage

// File: rtl/gp_timer_ctrl.sv
module gp_timer_ctrl
  import gp_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_setup,
  input  logic [CW-1:0] wdata,
  input  logic          hit1,
  input  logic          hit2,
  output cfg_t          cfg_q,
  output logic          run_q,
  output logic          f1_q,
  output logic          f2_q,
  output logic          init_q
);
  cfg_t cfg_d;
  logic run_d, f1_d, f2_d, init_d;

  always_comb begin
    cfg_d  = cfg_q;
    run_d  = run_q;
    f1_d   = f1_q;
    f2_d   = f2_q;
    init_d = init_q;
    if (wr_setup) begin
      if (!init_q) begin
        cfg_d  = cfg_t'(wdata[CFG_W-1:0]);
        init_d = 1'b1;
      end
      run_d = wdata[BIT_RUN];
      if (wdata[BIT_F1]) f1_d = 1'b0;
      if (wdata[BIT_F2]) f2_d = 1'b0;
    end
    if (hit1) f1_d = 1'b1;
    if (hit2) f2_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      run_q  <= 1'b0;
      f1_q   <= 1'b0;
      f2_q   <= 1'b0;
      init_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      run_q  <= run_d;
      f1_q   <= f1_d;
      f2_q   <= f2_d;
      init_q <= init_d;
    end
  end
endmodule

// File: rtl/gp_timer_presc.sv
module gp_timer_presc
  import gp_timer_pkg::*;
#(
  parameter int DW = (1 << PS_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] ps,
  output logic            step
);
  localparam int SHW = PS_W + 1;
  logic [DW-1:0]  div_q, div_d, lim;
  logic [SHW-1:0] sh;

  always_comb begin
    sh    = SHW'(DW) - {1'b0, ps};
    lim   = {DW{1'b1}} >> sh;
    step  = run & tick & ~clr & (div_q == lim);
    div_d = div_q;
    if (clr)
      div_d = '0;
    else if (run && tick)
      div_d = step ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/gp_timer_core.sv
module gp_timer_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          wr_cnt,
  input  logic          wr_c1,
  input  logic          wr_c2,
  input  logic [CW-1:0] wdata,
  input  logic          pwm_mode,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cmp1_q,
  output logic [CW-1:0] cmp2_q,
  output logic          hit1,
  output logic          hit2,
  output logic          out
);
  logic [CW-1:0] cnt_nx, cnt_d, cmp1_d, cmp2_d;
  logic          pulse_q;

  always_comb begin
    cnt_nx = (cnt_q == cmp2_q) ? '0 : cnt_q + 1'b1;
    hit1   = step & ~wr_cnt & (cnt_nx == cmp1_q);
    hit2   = step & ~wr_cnt & (cnt_nx == cmp2_q);
    cnt_d  = cnt_q;
    if (wr_cnt)    cnt_d = wdata;
    else if (step) cnt_d = cnt_nx;
    cmp1_d = wr_c1 ? wdata : cmp1_q;
    cmp2_d = wr_c2 ? wdata : cmp2_q;
    out    = pwm_mode ? (cnt_q >= cmp1_q) : pulse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp1_q  <= '1;
      cmp2_q  <= '1;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cmp1_q  <= cmp1_d;
      cmp2_q  <= cmp2_d;
      pulse_q <= hit1;
    end
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_fast_i,
  input  logic          tick_slow_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          irq_en1_i,
  input  logic          irq_en2_i,
  output logic [CW-1:0] setup_o,
  output logic [CW-1:0] count_o,
  output logic          cmp_out_o,
  output logic          irq_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  cfg_t          cfg_w;
  logic          run_w, f1_w, f2_w, init_w;
  logic          hit1_w, hit2_w, step_w, base_tick;
  logic          wr_setup_w, wr_cnt_w, wr_c1_w, wr_c2_w;
  logic [CW-1:0] cmp1_w, cmp2_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wr_setup_w = wr_en_i & (reg_sel_e'(wr_sel_i) == SEL_SETUP);
  assign wr_cnt_w   = wr_en_i & (reg_sel_e'(wr_sel_i) == SEL_COUNT);
  assign wr_c1_w    = wr_en_i & (reg_sel_e'(wr_sel_i) == SEL_CMP1);
  assign wr_c2_w    = wr_en_i & (reg_sel_e'(wr_sel_i) == SEL_CMP2);

  gp_timer_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .wr_setup(wr_setup_w), .wdata(wr_data_i),
    .hit1(hit1_w), .hit2(hit2_w), .cfg_q(cfg_w), .run_q(run_w),
    .f1_q(f1_w), .f2_q(f2_w), .init_q(init_w)
  );

  assign base_tick = cfg_w.csel ? tick_fast_i : tick_slow_i;

  gp_timer_presc u_presc (
    .clk(clk), .rst_n(rst_ni), .tick(base_tick), .run(run_w),
    .clr(wr_cnt_w), .ps(cfg_w.ps), .step(step_w)
  );

  gp_timer_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_ni), .step(step_w), .wr_cnt(wr_cnt_w),
    .wr_c1(wr_c1_w), .wr_c2(wr_c2_w), .wdata(wr_data_i),
    .pwm_mode(cfg_w.pwm), .cnt_q(count_o), .cmp1_q(cmp1_w),
    .cmp2_q(cmp2_w), .hit1(hit1_w), .hit2(hit2_w), .out(cmp_out_o)
  );

  always_comb begin
    setup_o                 = '0;
    setup_o[CFG_W-1:0]      = cfg_w;
    setup_o[BIT_RUN]        = run_w;
    setup_o[BIT_F1]         = f1_w;
    setup_o[BIT_F2]         = f2_w;
    setup_o[BIT_INIT]       = init_w;
  end

  assign irq_o = (f1_w & irq_en1_i) | (f2_w & irq_en2_i);
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          step,
  input logic          run,
  input logic          wr_cnt,
  input logic          wr_setup,
  input logic          hit1,
  input logic          init,
  input logic [5:0]    cfg,
  input logic          f1,
  input logic          f2,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp2
);
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (step && !wr_cnt && cnt == cmp2) |=> (cnt == '0));            // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run && !wr_cnt) |=> $stable(cnt));                          // R4
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    hit1 |=> f1);                                                 // R5
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_ni)
    init |=> $stable(cfg));                                       // R7
  AST_INIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_setup |=> init);                                           // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (f1 || f2));                                          // R9
endmodule

bind gp_timer gp_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .step(step_w), .run(run_w),
  .wr_cnt(wr_cnt_w), .wr_setup(wr_setup_w), .hit1(hit1_w),
  .init(init_w), .cfg(cfg_w), .f1(f1_w), .f2(f2_w), .irq(irq_o),
  .cnt(count_o), .cmp2(cmp2_w)
);

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, tick_fast, tick_slow, wr_en, en1, en2;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data, setup_o, count_o;
  logic        cmp_out, irq;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  gp_timer u_gp_timer (
    .clk(clk), .rst_n(rst_n), .tick_fast_i(tick_fast), .tick_slow_i(tick_slow),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .irq_en1_i(en1), .irq_en2_i(en2), .setup_o(setup_o), .count_o(count_o),
    .cmp_out_o(cmp_out), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    adv(2);
    rst_n = 1'b1;
    adv(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 setup", setup_o, 0);
    chk("R10 count", count_o, 0);
    chk("R9 irq", irq, 0);
  endtask

  task automatic t_event_mode();
    wr(2'd3, 16'd5);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0050);              // fast base, ps 0, event mode, run
    chk("R7 init", setup_o[9], 1);
    wr(2'd0, 16'h006F);              // config change must be ignored
    chk("R7 locked", setup_o[5:0], 6'h10);
    chk("R4 run", setup_o[6], 1);
    wr(2'd1, 16'd0);                 // R10 restart
    adv(2);
    chk("R8 pulse", cmp_out, 1);
    chk("R5 f1", setup_o[7], 1);
    adv(1);
    chk("R8 pulse end", cmp_out, 0);
    chk("R3 count", count_o, 3);
    chk("R5 f2 clear", setup_o[8], 0);
    adv(3);
    chk("R3 wrap", count_o, 0);
    chk("R5 f2", setup_o[8], 1);
  endtask

  task automatic t_clear_freeze();
    en1 = 1'b1; en2 = 1'b0;
    wr(2'd0, 16'h0000);              // stop, flags written 0
    chk("R6 zero keeps f1", setup_o[7], 1);
    chk("R6 zero keeps f2", setup_o[8], 1);
    chk("R9 irq on", irq, 1);
    en1 = 1'b0;
    adv(1);
    chk("R9 irq gated", irq, 0);
    en1 = 1'b1;
    begin
      logic [15:0] held;
      held = count_o;
      adv(5);
      chk("R4 frozen", count_o, held);
    end
    wr(2'd0, 16'h0080);
    chk("R6 f1 cleared", setup_o[7], 0);
    chk("R9 irq off", irq, 0);
    wr(2'd0, 16'h0100);
    chk("R6 f2 cleared", setup_o[8], 0);
  endtask

  task automatic t_full_range();
    wr(2'd3, 16'hFFFF);
    wr(2'd1, 16'hFFFE);
    wr(2'd0, 16'h0040);
    adv(1);
    chk("R3 at top", count_o, 16'hFFFF);
    chk("R5 f2 top", setup_o[8], 1);
    adv(1);
    chk("R3 full wrap", count_o, 0);
  endtask

  task automatic t_collision();
    do_reset();
    en1 = 1'b1;
    wr(2'd3, 16'd9);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0050);
    wr(2'd1, 16'd0);                 // count 0 at this edge
    wr(2'd0, 16'h00D0);              // clear of f1 lands on the step to 2
    chk("R5 set wins", setup_o[7], 1);
    chk("R9 irq held", irq, 1);
    adv(3);
    wr(2'd1, 16'd7);                 // write coincides with a step
    chk("R10 write wins", count_o, 7);
  endtask

  task automatic t_prescale();
    do_reset();
    tick_fast = 1'b1; tick_slow = 1'b0;
    wr(2'd0, 16'h0042);              // slow base, ps 2, run
    adv(5);
    chk("R2 fast ignored", count_o, 0);
    tick_slow = 1'b1;
    wr(2'd1, 16'd0);
    adv(3);
    chk("R1 not yet", count_o, 0);
    adv(1);
    chk("R1 first step", count_o, 1);
    adv(4);
    chk("R1 second step", count_o, 2);
    tick_slow = 1'b0;
  endtask

  task automatic t_pwm();
    do_reset();
    tick_fast = 1'b1;
    wr(2'd3, 16'd9);
    wr(2'd2, 16'd4);
    wr(2'd0, 16'h0070);              // fast, PWM, run
    wr(2'd1, 16'd0);
    adv(3);
    chk("R8 pwm low", cmp_out, 0);
    adv(1);
    chk("R8 pwm high", cmp_out, 1);
    adv(5);
    chk("R8 pwm top", count_o, 9);
    chk("R8 pwm still high", cmp_out, 1);
    adv(1);
    chk("R8 pwm period", cmp_out, 0);
  endtask

  initial begin
    rst_n = 1'b1; tick_fast = 1'b1; tick_slow = 1'b0; wr_en = 1'b0;
    wr_sel = 2'd0; wr_data = '0; en1 = 1'b0; en2 = 1'b0;
    t_reset();
    t_event_mode();
    t_clear_freeze();
    t_full_range();
    t_collision();
    t_prescale();
    t_pwm();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule